// File: doc/BRIEF.md
# Row-by-row correlated double sampling sequencer

This block paces the readout of a pixel matrix one row at a time. For every row it raises that row's gate-select line and, after a settle interval, has the downstream current memory take a first sample holding signal plus pedestal. It then drops the gate, fires the same row's clear line to empty the collected charge, raises the gate again and has a second sample taken, which now holds the pedestal alone. A one-cycle row-done strobe follows, telling downstream logic that both samples of the row exist and that their difference is the collected charge. No pedestal table is kept anywhere.

Each sample is taken in two passes: a coarse capture, then a fine resample that corrects the error of the coarse one, then a one-cycle shift that hands the result on. The sequencer drives these three strobes in that order for both samples. A flag marks which of the two samples is in progress. The lengths of the settle, coarse, clear and fine phases are cycle counts taken at start. A frame visits all rows in ascending order and then either stops or, in continuous mode, wraps to row 0 at once. The block is meant to run at about 50 MHz.

Top module: `row_cds_sequencer`

## Requirements
- R1: After reset, busy is 0, every gate and clear line is 0, every strobe is 0 and the row index is 0.
- R2: A start pulse sampled while idle makes busy 1 from the next cycle on, and the frame visits rows 0 to ROWS-1 in ascending order, one row at a time.
- R3: Each row runs, in this order: gate on for S settle cycles; gate on with coarse strobe for C cycles; gate on with fine strobe for F cycles; gate on with shift strobe for 1 cycle; clear on, gate off, for K cycles; then coarse (C), fine (F) and shift (1) again with gate on; then 1 cycle of row-done with every gate and clear line off. The sample flag is 0 during the first sample's strobes and 1 during the second's.
- R4: Gate line n and clear line n are bit n of their buses; only the current row's line can be on, and gate and clear are never on together.
- R5: A length input of 0 is taken as 1, and lengths are sampled only at start, so changing them during a frame has no effect on that frame.
- R6: The row index output equals the current row and holds steady from the first settle cycle through row-done of that row.
- R7: With continuous mode 0 at the last row's row-done cycle, busy is 0 in the following cycle and all outputs are idle.
- R8: With continuous mode 1 at the last row's row-done cycle, the next cycle is the first settle cycle of row 0 with busy held at 1.
- R9: A start pulse while busy is ignored: the running sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a frame when idle |
| continuous_i | input | 1 | Wrap to row 0 after the last row instead of stopping |
| settle_len_i | input | LEN_W | Settle cycles after gate rises (0 means 1) |
| sample_len_i | input | LEN_W | Coarse sample cycles (0 means 1) |
| clear_len_i | input | LEN_W | Clear pulse cycles (0 means 1) |
| fine_len_i | input | LEN_W | Fine resample cycles (0 means 1) |
| gate_row_o | output | ROWS | One-hot gate-select lines |
| clear_row_o | output | ROWS | One-hot clear lines |
| coarse_stb_o | output | 1 | Coarse sample strobe |
| fine_stb_o | output | 1 | Fine resample strobe |
| shift_stb_o | output | 1 | Hand-on strobe after the fine pass |
| pedestal_phase_o | output | 1 | 0 during the signal+pedestal sample, 1 during the pedestal sample |
| row_done_o | output | 1 | Both samples of the current row are complete |
| row_idx_o | output | $clog2(ROWS) | Current row |
| busy_o | output | 1 | A frame is in progress |

## Verification
The hardest situation to reach is the frame boundary under continuous mode, where the last row's row-done cycle must hand over directly to row 0 without an idle cycle while a later frame must still stop cleanly. The bench runs back-to-back frames, lowering the mode input only before the final frame, and compares every cycle of every row against a phase schedule derived from the lengths. It also disturbs a running frame with a start pulse and new length values in the middle of a row, and checks that the schedule of the whole frame stays as originally latched.

// File: rtl/row_cds_sequencer.sv
module row_cds_sequencer #(
  parameter int ROWS  = 128,
  parameter int LEN_W = 8,
  localparam int IDX_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             continuous_i,
  input  logic [LEN_W-1:0] settle_len_i,
  input  logic [LEN_W-1:0] sample_len_i,
  input  logic [LEN_W-1:0] clear_len_i,
  input  logic [LEN_W-1:0] fine_len_i,
  output logic [ROWS-1:0]  gate_row_o,
  output logic [ROWS-1:0]  clear_row_o,
  output logic             coarse_stb_o,
  output logic             fine_stb_o,
  output logic             shift_stb_o,
  output logic             pedestal_phase_o,
  output logic             row_done_o,
  output logic [IDX_W-1:0] row_idx_o,
  output logic             busy_o
);

  typedef enum logic [3:0] {
    PH_IDLE, PH_SETTLE, PH_COARSE_A, PH_FINE_A, PH_SHIFT_A,
    PH_CLEAR, PH_COARSE_B, PH_FINE_B, PH_SHIFT_B, PH_DONE
  } phase_t;

  localparam logic [IDX_W-1:0] LAST_ROW = IDX_W'(ROWS - 1);

  phase_t           phase_q, phase_d;
  logic [LEN_W-1:0] cnt_q;
  logic [IDX_W-1:0] row_q;
  logic [LEN_W-1:0] s_len_q, c_len_q, k_len_q, f_len_q;
  logic             last_row, gate_on;

  function automatic logic [LEN_W-1:0] at_least_one(input logic [LEN_W-1:0] x);
    return (x == '0) ? LEN_W'(1) : x;
  endfunction

  function automatic logic [LEN_W-1:0] reload(input phase_t p,
      input logic [LEN_W-1:0] s, input logic [LEN_W-1:0] c,
      input logic [LEN_W-1:0] k, input logic [LEN_W-1:0] f);
    case (p)
      PH_SETTLE:               return s - 1'b1;
      PH_COARSE_A, PH_COARSE_B: return c - 1'b1;
      PH_FINE_A, PH_FINE_B:     return f - 1'b1;
      PH_CLEAR:                return k - 1'b1;
      default:                 return '0;
    endcase
  endfunction

  assign last_row = (row_q == LAST_ROW);

  always_comb begin
    case (phase_q)
      PH_SETTLE:   phase_d = PH_COARSE_A;
      PH_COARSE_A: phase_d = PH_FINE_A;
      PH_FINE_A:   phase_d = PH_SHIFT_A;
      PH_SHIFT_A:  phase_d = PH_CLEAR;
      PH_CLEAR:    phase_d = PH_COARSE_B;
      PH_COARSE_B: phase_d = PH_FINE_B;
      PH_FINE_B:   phase_d = PH_SHIFT_B;
      PH_SHIFT_B:  phase_d = PH_DONE;
      PH_DONE:     phase_d = (last_row && !continuous_i) ? PH_IDLE : PH_SETTLE;
      default:     phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      row_q   <= '0;
      s_len_q <= LEN_W'(1);
      c_len_q <= LEN_W'(1);
      k_len_q <= LEN_W'(1);
      f_len_q <= LEN_W'(1);
    end else if (phase_q == PH_IDLE) begin
      if (start_i) begin
        s_len_q <= at_least_one(settle_len_i);
        c_len_q <= at_least_one(sample_len_i);
        k_len_q <= at_least_one(clear_len_i);
        f_len_q <= at_least_one(fine_len_i);
        cnt_q   <= at_least_one(settle_len_i) - 1'b1;
        row_q   <= '0;
        phase_q <= PH_SETTLE;
      end
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= reload(phase_d, s_len_q, c_len_q, k_len_q, f_len_q);
      if (phase_q == PH_DONE)
        row_q <= last_row ? '0 : row_q + 1'b1;
    end
  end

  assign gate_on = (phase_q != PH_IDLE) && (phase_q != PH_CLEAR) && (phase_q != PH_DONE);

  assign gate_row_o  = gate_on ? ({{(ROWS-1){1'b0}}, 1'b1} << row_q) : '0;
  assign clear_row_o = (phase_q == PH_CLEAR) ? ({{(ROWS-1){1'b0}}, 1'b1} << row_q) : '0;

  assign coarse_stb_o     = (phase_q == PH_COARSE_A) || (phase_q == PH_COARSE_B);
  assign fine_stb_o       = (phase_q == PH_FINE_A)   || (phase_q == PH_FINE_B);
  assign shift_stb_o      = (phase_q == PH_SHIFT_A)  || (phase_q == PH_SHIFT_B);
  assign pedestal_phase_o = (phase_q == PH_COARSE_B) || (phase_q == PH_FINE_B) ||
                            (phase_q == PH_SHIFT_B);
  assign row_done_o       = (phase_q == PH_DONE);
  assign row_idx_o        = row_q;
  assign busy_o           = (phase_q != PH_IDLE);

endmodule

module row_cds_sequencer_chk #(
  parameter int ROWS  = 128,
  parameter int IDX_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic [ROWS-1:0]  gate_row_o,
  input logic [ROWS-1:0]  clear_row_o,
  input logic             coarse_stb_o,
  input logic             fine_stb_o,
  input logic             shift_stb_o,
  input logic             pedestal_phase_o,
  input logic             row_done_o,
  input logic [IDX_W-1:0] row_idx_o,
  input logic             busy_o
);

  a_r4_gate_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gate_row_o));

  a_r4_clear_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clear_row_o));

  a_r4_no_gate_with_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !((|gate_row_o) && (|clear_row_o)));

  a_r3_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({coarse_stb_o, fine_stb_o, shift_stb_o, row_done_o, |clear_row_o}));

  a_r3_shift_single: assert property (@(posedge clk) disable iff (!rst_n)
    shift_stb_o |=> !shift_stb_o);

  a_r3_clear_then_pedestal: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(|clear_row_o) |-> (coarse_stb_o && pedestal_phase_o));

  a_r3_done_lines_off: assert property (@(posedge clk) disable iff (!rst_n)
    row_done_o |-> (gate_row_o == '0 && clear_row_o == '0));

  a_r6_row_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && !$past(row_done_o)) |-> $stable(row_idx_o));

  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (gate_row_o == '0 && clear_row_o == '0 && !coarse_stb_o &&
                 !fine_stb_o && !shift_stb_o && !row_done_o));

endmodule

bind row_cds_sequencer row_cds_sequencer_chk #(.ROWS(ROWS), .IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .gate_row_o(gate_row_o), .clear_row_o(clear_row_o),
  .coarse_stb_o(coarse_stb_o), .fine_stb_o(fine_stb_o), .shift_stb_o(shift_stb_o),
  .pedestal_phase_o(pedestal_phase_o), .row_done_o(row_done_o),
  .row_idx_o(row_idx_o), .busy_o(busy_o)
);

// File: tb/row_cds_sequencer_tb.sv
module row_cds_sequencer_tb_top;
  localparam int ROWS  = 5;
  localparam int LEN_W = 4;
  localparam int IDX_W = $clog2(ROWS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, continuous_i = 1'b0;
  logic [LEN_W-1:0] settle_len_i = '0, sample_len_i = '0, clear_len_i = '0, fine_len_i = '0;
  logic [ROWS-1:0] gate_row_o, clear_row_o;
  logic coarse_stb_o, fine_stb_o, shift_stb_o, pedestal_phase_o, row_done_o, busy_o;
  logic [IDX_W-1:0] row_idx_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  row_cds_sequencer #(.ROWS(ROWS), .LEN_W(LEN_W)) dut_i (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // packed view: {busy, done, ped, shift, fine, coarse, clear_any, gate_any}
  function automatic logic [7:0] view_now();
    return {busy_o, row_done_o, pedestal_phase_o, shift_stb_o, fine_stb_o,
            coarse_stb_o, |clear_row_o, |gate_row_o};
  endfunction

  function automatic logic [7:0] view_exp(input int t, input int s, input int c,
                                          input int k, input int f);
    int b0 = s, b1 = b0 + c, b2 = b1 + f, b3 = b2 + 1, b4 = b3 + k;
    int b5 = b4 + c, b6 = b5 + f, b7 = b6 + 1;
    if (t < b0) return 8'b1000_0001;
    if (t < b1) return 8'b1000_0101;
    if (t < b2) return 8'b1000_1001;
    if (t < b3) return 8'b1001_0001;
    if (t < b4) return 8'b1000_0010;
    if (t < b5) return 8'b1010_0101;
    if (t < b6) return 8'b1010_1001;
    if (t < b7) return 8'b1011_0001;
    return 8'b1100_0000;
  endfunction

  function automatic int clamp(input int x);
    return (x == 0) ? 1 : x;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Runs `frames` frames starting with a start pulse; optionally disturbs mid-frame.
  task automatic run_frames(input int s, input int c, input int k, input int f,
                            input int frames, input bit disturb, input string tag);
    int ls = clamp(s), lc = clamp(c), lk = clamp(k), lf = clamp(f);
    int per_row = ls + 2*lc + 2*lf + lk + 3;
    settle_len_i = LEN_W'(s); sample_len_i = LEN_W'(c);
    clear_len_i = LEN_W'(k); fine_len_i = LEN_W'(f);
    continuous_i = (frames > 1);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int fr = 0; fr < frames; fr++) begin
      if (fr == frames - 1) continuous_i = 1'b0;
      for (int r = 0; r < ROWS; r++) begin
        bit row_ok = 1'b1;
        logic [7:0] bad_act = '0, bad_exp = '0;
        for (int t = 0; t < per_row; t++) begin
          logic [7:0] e = view_exp(t, ls, lc, lk, lf);
          logic [ROWS-1:0] line = ROWS'(1) << r;
          if (view_now() !== e && row_ok) begin row_ok = 0; bad_act = view_now(); bad_exp = e; end
          if (e[0] && gate_row_o !== line) row_ok = 0;
          if (e[1] && clear_row_o !== line) row_ok = 0;
          if (row_idx_o !== IDX_W'(r)) row_ok = 0;
          if (disturb && r == 1 && t == 2) begin
            start_i = 1'b1;
            settle_len_i = LEN_W'(s + 3); sample_len_i = LEN_W'(c + 2);
            clear_len_i = '0; fine_len_i = LEN_W'(f + 1);
          end else begin
            start_i = 1'b0;
          end
          @(negedge clk);
        end
        check(row_ok, tag, $sformatf("frame %0d row %0d schedule R3 R4 R6", fr, r),
              {24'd0, bad_act}, {24'd0, bad_exp});
      end
      if (fr < frames - 1)
        check(busy_o && row_idx_o == '0 && gate_row_o == ROWS'(1) && !coarse_stb_o,
              "R8", "wrap to row 0 settle", {31'd0, busy_o}, 32'd1);
    end
    check(!busy_o && gate_row_o == '0 && clear_row_o == '0 && !row_done_o,
          "R7", "idle after last row", {31'd0, busy_o}, 32'd0);
  endtask

  task automatic test_reset();
    do_reset();
    check(!busy_o, "R1", "busy after reset", {31'd0, busy_o}, 0);
    check(gate_row_o == '0 && clear_row_o == '0, "R1", "lines after reset",
          {27'd0, gate_row_o | clear_row_o}, 0);
    check({coarse_stb_o, fine_stb_o, shift_stb_o, row_done_o, pedestal_phase_o} == '0,
          "R1", "strobes after reset",
          {27'd0, coarse_stb_o, fine_stb_o, shift_stb_o, row_done_o, pedestal_phase_o}, 0);
    check(row_idx_o == '0, "R1", "row index after reset", {29'd0, row_idx_o}, 0);
  endtask

  task automatic test_basic();   run_frames(1, 1, 1, 1, 1, 0, "R2"); endtask
  task automatic test_lengths(); run_frames(3, 2, 2, 4, 1, 0, "R3"); endtask
  task automatic test_zero();    run_frames(0, 0, 0, 0, 1, 0, "R5"); endtask
  task automatic test_disturb(); run_frames(2, 1, 3, 2, 1, 1, "R9"); endtask
  task automatic test_cont();    run_frames(1, 2, 1, 1, 3, 0, "R8"); endtask

  task automatic test_idle_hold();
    repeat (4) @(negedge clk);
    check(!busy_o && gate_row_o == '0, "R7", "stays idle without start",
          {31'd0, busy_o}, 0);
  endtask

  initial begin
    test_reset();
    test_basic();
    test_lengths();
    test_zero();
    test_disturb();
    test_cont();
    test_idle_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule